// File: doc/BRIEF.md
# Per-Address Ordered Atomic Request Hub

This block sits between one requester and one memory port. It accepts reads, writes and atomic operations, each carrying a request ID, an address, a 4-byte or 8-byte size, a data word and (for compare-and-swap) a compare word. Requests that target the same address are executed strictly one at a time, in the order they were accepted. Requests to different addresses run side by side, so several memory transactions can be in flight at once.

The hub keeps a small table of tracking entries. Each entry owns one address and holds a FIFO of the requests waiting on that address. The head of each FIFO is the only request of that address that may touch memory. An atomic is carried out inside the hub in three steps: a memory read, a local modify, and a memory write of the result. The atomic stays at the head until the write is acknowledged. Each request produces exactly one completion, tagged with its ID. A read completes with the data read. An atomic completes with the memory value as it was before the operation. A write completes with zero.

Top module: `ordered_atomic_hub`

## Requirements
- R1: While reset is high and on the cycle after it, `mem_valid` and `cpl_valid` are low. Once reset has been released and no request is waiting, `req_ready` is high.
- R2: A request accepted at clock edge k, when no other request to its address is being tracked, raises `mem_valid` at edge k+1 with its address, provided the memory port is idle.
- R3: The memory port never carries two outstanding transactions to the same address. A request whose address already has an in-flight request is held in that address's FIFO.
- R4: Completions for requests to one address appear in the order in which those requests were accepted.
- R5: `req_op` uses these encodings: 0 read, 1 write, 2 add, 3 swap, 4 AND, 5 OR, 6 compare-and-swap. For an atomic, `req_wdata` is the operand. The atomic reads memory, writes back the result to the same address with the same size, and completes with the value read.
- R6: Compare-and-swap writes `req_wdata` when the old value equals `req_cmp`. Otherwise it writes the old value back unchanged.
- R7: `req_size8`=0 selects 4 bytes, meaning the low 32 bits (little-endian). Atomic arithmetic then wraps at 32 bits, returned data is zero-extended, and a 4-byte write leaves the upper half of the stored word intact. `req_size8`=1 selects a full 64-bit operation.
- R8: A request queued behind an atomic observes the atomic's result, because it is not issued until the atomic's write-back is acknowledged.
- R9: Requests to different addresses can be outstanding on the memory port at the same time.
- R10: `req_ready` is low in two cases: the request's address is tracked and its FIFO already holds DEPTH requests, or the address is untracked and all ENTRIES entries are in use. An entry becomes reusable once its FIFO drains.
- R11: Each request yields exactly one completion carrying its `req_id`. The completion is presented the cycle after the memory response that finishes the request. A write completes with data zero.
- R12: While `mem_valid` is high and `mem_ready` is low, the memory request fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_id | input | 4 | Requester tag returned with the completion |
| req_op | input | 3 | Operation code (see R5) |
| req_addr | input | 32 | Target address |
| req_size8 | input | 1 | 1 = 8 bytes, 0 = 4 bytes |
| req_wdata | input | 64 | Write data, atomic operand or swap value |
| req_cmp | input | 64 | Compare value for compare-and-swap |
| mem_valid | output | 1 | Memory transaction present |
| mem_ready | input | 1 | Memory accepts the transaction |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_tag | output | 2 | Tracking-entry tag, echoed on the response |
| mem_addr | output | 32 | Memory address |
| mem_size8 | output | 1 | Transaction size |
| mem_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Memory response (read data or write acknowledge) |
| mem_rsp_tag | input | 2 | Tag of the responding transaction |
| mem_rsp_data | input | 64 | Read data |
| cpl_valid | output | 1 | Completion present |
| cpl_id | output | 4 | ID of the completed request |
| cpl_data | output | 64 | Read data, old value, or zero |

## Verification
A request accepted at edge k enters its FIFO at that edge, and the registered memory stage raises `mem_valid` one edge later. The issue-latency check samples just after edge k (expecting low) and just after edge k+1 (expecting high with the address). A memory response presented at edge r is turned into a registered completion at the same edge, so completions are collected at the following falling edge and compared by ID against values computed from the operation rules. Ordering, hazard and stall-hold results are read from the bench's memory model at falling edges, away from the edges where the hub changes state.

// File: rtl/hub_pkg.sv
package hub_pkg;
  parameter int HUB_AW  = 32;
  parameter int HUB_DW  = 64;
  parameter int HUB_IDW = 4;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ADD   = 3'd2,
    OP_SWAP  = 3'd3,
    OP_AND   = 3'd4,
    OP_OR    = 3'd5,
    OP_CAS   = 3'd6
  } hub_op_e;

  typedef enum logic [1:0] {
    ST_READY,    // head waits to be issued
    ST_WAIT_RD,  // read (plain or atomic fetch) in flight
    ST_NEED_WB,  // atomic result computed, write-back not yet issued
    ST_WAIT_WB   // write or atomic write-back in flight
  } hub_st_e;

  typedef struct packed {
    logic [HUB_IDW-1:0] id;
    hub_op_e            op;
    logic               size8;
    logic [HUB_DW-1:0]  wdata;
    logic [HUB_DW-1:0]  cmp;
  } hub_req_t;

  function automatic logic is_atomic(hub_op_e op);
    return !(op == OP_READ || op == OP_WRITE);
  endfunction

  function automatic logic [HUB_DW-1:0] size_mask(logic size8);
    return size8 ? {HUB_DW{1'b1}} : {{(HUB_DW-32){1'b0}}, 32'hFFFF_FFFF};
  endfunction
endpackage

// File: rtl/hub_fifo.sv
module hub_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;

  // storage has no reset so it can map onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = store[rd_ptr];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/hub_rr_arb.sv
module hub_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gidx
);
  logic [IW-1:0] last;

  always_comb begin
    logic found;
    int   k;
    found = 1'b0;
    gnt   = '0;
    gidx  = '0;
    for (int i = 0; i < N; i++) begin
      k = (int'(last) + 1 + i) % N;
      if (!found && req[k]) begin
        found  = 1'b1;
        gnt[k] = 1'b1;
        gidx   = IW'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                last <= IW'(N - 1);
    else if (adv && |req)   last <= gidx;
  end
endmodule

// File: rtl/hub_alu.sv
module hub_alu
  import hub_pkg::*;
(
  input  hub_op_e           op,
  input  logic              size8,
  input  logic [HUB_DW-1:0] old_v,
  input  logic [HUB_DW-1:0] operand,
  input  logic [HUB_DW-1:0] cmp_v,
  output logic [HUB_DW-1:0] new_v
);
  logic [HUB_DW-1:0] m, o, a, c, r;

  always_comb begin
    m = size_mask(size8);
    o = old_v & m;
    a = operand & m;
    c = cmp_v & m;
    case (op)
      OP_ADD:  r = o + a;
      OP_SWAP: r = a;
      OP_AND:  r = o & a;
      OP_OR:   r = o | a;
      OP_CAS:  r = (o == c) ? a : o;
      default: r = o;
    endcase
    new_v = r & m;
  end
endmodule

// File: rtl/ordered_atomic_hub.sv
module ordered_atomic_hub
  import hub_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int DEPTH   = 4,
  localparam int TW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [HUB_IDW-1:0] req_id,
  input  logic [2:0]         req_op,
  input  logic [HUB_AW-1:0]  req_addr,
  input  logic               req_size8,
  input  logic [HUB_DW-1:0]  req_wdata,
  input  logic [HUB_DW-1:0]  req_cmp,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic               mem_write,
  output logic [TW-1:0]      mem_tag,
  output logic [HUB_AW-1:0]  mem_addr,
  output logic               mem_size8,
  output logic [HUB_DW-1:0]  mem_wdata,
  input  logic               mem_rsp_valid,
  input  logic [TW-1:0]      mem_rsp_tag,
  input  logic [HUB_DW-1:0]  mem_rsp_data,
  output logic               cpl_valid,
  output logic [HUB_IDW-1:0] cpl_id,
  output logic [HUB_DW-1:0]  cpl_data
);
  hub_req_t          in_req;
  hub_req_t          head    [ENTRIES];
  logic [HUB_AW-1:0] ent_addr[ENTRIES];
  hub_st_e           st      [ENTRIES];
  logic [HUB_DW-1:0] old_q   [ENTRIES];
  logic [HUB_DW-1:0] wb_q    [ENTRIES];

  logic [ENTRIES-1:0] empty, full, match, push, pop, elig, gnt, alloc_oh;
  logic [TW-1:0]      gidx;
  logic               any_match, any_free, accept, load, adv;

  assign in_req = '{id: req_id, op: hub_op_e'(req_op), size8: req_size8,
                    wdata: req_wdata, cmp: req_cmp};

  // ---------------- tracking entries ----------------
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    hub_fifo #(.W($bits(hub_req_t)), .DEPTH(DEPTH)) u_fifo (
      .clk  (clk),
      .rst  (rst),
      .push (push[e]),
      .pop  (pop[e]),
      .din  (in_req),
      .head (head[e]),
      .empty(empty[e]),
      .full (full[e])
    );
    assign match[e] = !empty[e] && (ent_addr[e] == req_addr);
    assign elig[e]  = !empty[e] && (st[e] == ST_READY || st[e] == ST_NEED_WB);
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    alloc_oh = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!found && empty[e]) begin
        found       = 1'b1;
        alloc_oh[e] = 1'b1;
      end
    end
  end

  assign any_match = |match;
  assign any_free  = |empty;
  assign req_ready = any_match ? !(|(match & full)) : any_free;
  assign accept    = req_valid && req_ready;
  assign push      = accept ? (any_match ? match : alloc_oh) : '0;

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++)
      if (accept && !any_match && alloc_oh[e]) ent_addr[e] <= req_addr;
  end

  // ---------------- issue side ----------------
  assign load = !mem_valid || mem_ready;
  assign adv  = load && |elig;

  hub_rr_arb #(.N(ENTRIES)) u_arb (
    .clk (clk),
    .rst (rst),
    .req (elig),
    .adv (adv),
    .gnt (gnt),
    .gidx(gidx)
  );

  hub_req_t g_head;
  hub_st_e  g_st;
  assign g_head = head[gidx];
  assign g_st   = st[gidx];

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
    end else if (load) begin
      mem_valid <= |elig;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      mem_tag   <= gidx;
      mem_addr  <= ent_addr[gidx];
      mem_size8 <= g_head.size8;
      mem_write <= (g_st == ST_NEED_WB) || (g_head.op == OP_WRITE);
      mem_wdata <= (g_st == ST_NEED_WB) ? wb_q[gidx]
                                        : (g_head.wdata & size_mask(g_head.size8));
    end
  end

  // ---------------- response side ----------------
  hub_req_t          r_head;
  hub_st_e           r_st;
  logic [HUB_DW-1:0] rd_m, alu_new;
  logic              rsp_atom_rd, done;

  assign r_head      = head[mem_rsp_tag];
  assign r_st        = st[mem_rsp_tag];
  assign rd_m        = mem_rsp_data & size_mask(r_head.size8);
  assign rsp_atom_rd = mem_rsp_valid && (r_st == ST_WAIT_RD) && is_atomic(r_head.op);
  assign done        = mem_rsp_valid && !rsp_atom_rd;

  hub_alu u_alu (
    .op     (r_head.op),
    .size8  (r_head.size8),
    .old_v  (rd_m),
    .operand(r_head.wdata),
    .cmp_v  (r_head.cmp),
    .new_v  (alu_new)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_pop
    assign pop[e] = done && (mem_rsp_tag == TW'(e));
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (rst)
        st[e] <= ST_READY;
      else if (adv && gnt[e])
        st[e] <= (st[e] == ST_NEED_WB || head[e].op == OP_WRITE) ? ST_WAIT_WB : ST_WAIT_RD;
      else if (mem_rsp_valid && mem_rsp_tag == TW'(e))
        st[e] <= rsp_atom_rd ? ST_NEED_WB : ST_READY;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (rsp_atom_rd && mem_rsp_tag == TW'(e)) begin
        old_q[e] <= rd_m;
        wb_q[e]  <= alu_new;
      end
    end
  end

  // ---------------- completion ----------------
  always_ff @(posedge clk) begin
    if (rst) cpl_valid <= 1'b0;
    else     cpl_valid <= done;
  end

  always_ff @(posedge clk) begin
    if (done) begin
      cpl_id   <= r_head.id;
      cpl_data <= (r_st == ST_WAIT_RD) ? rd_m
                : (is_atomic(r_head.op) ? old_q[mem_rsp_tag] : '0);
    end
  end
endmodule

// File: rtl/hub_checker.sv
module hub_checker #(
  parameter int ENTRIES = 4,
  parameter int TW      = 2,
  parameter int AW      = 32,
  parameter int DW      = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_write,
  input logic [TW-1:0] mem_tag,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_rsp_valid,
  input logic [TW-1:0] mem_rsp_tag,
  input logic          cpl_valid
);
  logic [ENTRIES-1:0] busy;

  always_ff @(posedge clk) begin
    if (rst) busy <= '0;
    else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (mem_valid && mem_ready && mem_tag == TW'(e))            busy[e] <= 1'b1;
        else if (mem_rsp_valid && mem_rsp_tag == TW'(e))            busy[e] <= 1'b0;
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!mem_valid && !cpl_valid)); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_tag)
                                   && $stable(mem_write) && $stable(mem_wdata))); // R12

  AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready) |-> !busy[mem_tag]); // R3

  AST_CPL_FROM_RSP: assert property (@(posedge clk) disable iff (rst)
    cpl_valid |-> $past(mem_rsp_valid)); // R11
endmodule

bind ordered_atomic_hub hub_checker #(
  .ENTRIES(ENTRIES), .TW(TW), .AW(hub_pkg::HUB_AW), .DW(hub_pkg::HUB_DW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mem_valid    (mem_valid),
  .mem_ready    (mem_ready),
  .mem_write    (mem_write),
  .mem_tag      (mem_tag),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_tag  (mem_rsp_tag),
  .cpl_valid    (cpl_valid)
);

// File: tb/tb_ordered_atomic_hub.sv
`timescale 1ns/100ps
module tb_ordered_atomic_hub;
  import hub_pkg::*;
  localparam int TW  = 2;
  localparam int LAT = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;   // 250 MHz

  logic              req_valid = 1'b0, req_ready, req_size8 = 1'b1;
  logic [3:0]        req_id = '0;
  logic [2:0]        req_op = '0;
  logic [31:0]       req_addr = '0;
  logic [63:0]       req_wdata = '0, req_cmp = '0;
  logic              mem_valid, mem_ready = 1'b1, mem_write, mem_size8;
  logic [TW-1:0]     mem_tag, mem_rsp_tag = '0;
  logic [31:0]       mem_addr;
  logic [63:0]       mem_wdata, mem_rsp_data = '0;
  logic              mem_rsp_valid = 1'b0;
  logic              cpl_valid;
  logic [3:0]        cpl_id;
  logic [63:0]       cpl_data;

  ordered_atomic_hub dut (.*);

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  typedef struct { int tag; logic [63:0] data; int due; int a; } rsp_t;
  rsp_t        rq[$];
  logic [63:0] mem_words[16];
  int          out_cnt[16];
  int          out_total = 0, max_out = 0, dup_err = 0, stall_err = 0, stall_mode = 0;
  bit          hold_rsp = 0, prev_stall = 0;
  logic [31:0] p_addr;
  logic [63:0] p_wdata;
  logic        p_write;

  always @(negedge clk) begin
    if (rst) begin
      mem_rsp_valid = 1'b0;
      mem_ready = 1'b1;
      prev_stall = 0;
    end else begin
      if (prev_stall && !(mem_valid && mem_addr == p_addr && mem_wdata == p_wdata && mem_write == p_write))
        stall_err++;
      if (!hold_rsp && rq.size() > 0 && rq[0].due <= cyc) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_tag   = TW'(rq[0].tag);
        mem_rsp_data  = rq[0].data;
        out_cnt[rq[0].a]--;
        out_total--;
        void'(rq.pop_front());
      end else mem_rsp_valid = 1'b0;
      mem_ready = (stall_mode == 0) ? 1'b1 : (cyc % 3 == 0);
      if (mem_valid && mem_ready) begin
        automatic int a = int'(mem_addr[3:0]);
        automatic logic [63:0] rd = mem_words[a];
        if (out_cnt[a] != 0) dup_err++;
        out_cnt[a]++;
        out_total++;
        if (out_total > max_out) max_out = out_total;
        if (mem_write) begin
          if (mem_size8) mem_words[a] = mem_wdata;
          else           mem_words[a][31:0] = mem_wdata[31:0];
        end
        rq.push_back('{tag: int'(mem_tag), data: rd, due: cyc + LAT, a: a});
      end
      prev_stall = mem_valid && !mem_ready;
      p_addr = mem_addr; p_wdata = mem_wdata; p_write = mem_write;
    end
  end

  // ---------------- completion monitor ----------------
  logic [63:0] got[16];
  bit          gotv[16];
  int          ord[64];
  int          ord_n = 0, dup_cpl = 0;

  always @(negedge clk) begin
    if (!rst && cpl_valid) begin
      if (gotv[cpl_id]) dup_cpl++;
      gotv[cpl_id] = 1;
      got[cpl_id]  = cpl_data;
      if (ord_n < 64) ord[ord_n] = int'(cpl_id);
      ord_n++;
    end
  end

  task automatic clear();
    for (int i = 0; i < 16; i++) gotv[i] = 0;
    ord_n = 0;
  endtask

  task automatic send(input int id, input hub_op_e op, input int addr, input bit s8,
                      input logic [63:0] wd, input logic [63:0] cp = '0);
    @(negedge clk);
    req_valid = 1'b1; req_id = 4'(id); req_op = op; req_addr = 32'(addr);
    req_size8 = s8; req_wdata = wd; req_cmp = cp;
    #0.5;
    while (!req_ready) begin
      @(negedge clk);
      #0.5;
    end
    @(posedge clk);
    #0.2;
    req_valid = 1'b0;
  endtask

  task automatic wait_cpl(input int n, input string req);
    int t = 0;
    while (ord_n < n && t < 2000) begin
      @(negedge clk);
      t++;
    end
    #0.5;
    chk(ord_n >= n, req, 64'(ord_n), 64'(n));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk(!mem_valid && !cpl_valid, "R1 outputs quiet in reset", {mem_valid, cpl_valid}, 0);
    repeat (3) @(posedge clk);
    #0.2 rst = 1'b0;
    @(negedge clk);
    chk(!mem_valid && !cpl_valid, "R1 outputs quiet after reset", {mem_valid, cpl_valid}, 0);
    chk(req_ready, "R1 ready after reset", 64'(req_ready), 1);
  endtask

  task automatic t_latency();
    clear();
    mem_words[1] = 64'hA5;
    send(9, OP_READ, 1, 1, 0);
    chk(!mem_valid, "R2 no issue on accept edge", 64'(mem_valid), 0);
    @(posedge clk);
    #0.2;
    chk(mem_valid && mem_addr == 1 && !mem_write, "R2 issued one edge after accept", mem_addr, 1);
    wait_cpl(1, "R11 read completes");
    chk(gotv[9] && got[9] == 64'hA5, "R11 completion carries id and data", got[9], 64'hA5);
  endtask

  task automatic t_order();
    clear();
    dup_err = 0;
    mem_words[2] = 0;
    send(1, OP_WRITE, 2, 1, 10);
    send(2, OP_ADD,   2, 1, 5);
    send(3, OP_READ,  2, 1, 0);
    send(4, OP_SWAP,  2, 1, 99);
    send(5, OP_READ,  2, 1, 0);
    wait_cpl(5, "R4 five completions");
    for (int i = 0; i < 5; i++) chk(ord[i] == i + 1, "R4 same-address order", 64'(ord[i]), 64'(i + 1));
    chk(got[1] == 0,  "R11 write completes with zero", got[1], 0);
    chk(got[2] == 10, "R5 add returns old value", got[2], 10);
    chk(got[3] == 15, "R8 read sees add result", got[3], 15);
    chk(got[4] == 15, "R5 swap returns old value", got[4], 15);
    chk(got[5] == 99, "R8 read sees swap result", got[5], 99);
    chk(dup_err == 0, "R3 single in-flight per address", 64'(dup_err), 0);
  endtask

  task automatic t_ops();
    clear();
    mem_words[3] = 64'hF0F0;
    send(1, OP_AND, 3, 1, 64'hFF00);
    send(2, OP_OR,  3, 1, 64'h000F);
    send(3, OP_CAS, 3, 1, 64'h1234, 64'hF00F);
    send(4, OP_CAS, 3, 1, 64'h5555, 64'h9999);
    send(5, OP_READ, 3, 1, 0);
    wait_cpl(5, "R5 op sequence completes");
    chk(got[1] == 64'hF0F0, "R5 AND old value", got[1], 64'hF0F0);
    chk(got[2] == 64'hF000, "R5 OR sees AND result", got[2], 64'hF000);
    chk(got[3] == 64'hF00F, "R6 CAS match old value", got[3], 64'hF00F);
    chk(got[4] == 64'h1234, "R6 CAS mismatch old value", got[4], 64'h1234);
    chk(got[5] == 64'h1234 && mem_words[3] == 64'h1234, "R6 CAS mismatch leaves value", got[5], 64'h1234);
  endtask

  task automatic t_size4();
    clear();
    mem_words[4] = 64'h1111_2222_FFFF_FFFF;
    mem_words[5] = 64'hFFFF_FFFF;
    send(1, OP_ADD,  4, 0, 64'h7_0000_0001);
    send(2, OP_READ, 4, 1, 0);
    send(3, OP_READ, 4, 0, 0);
    send(4, OP_ADD,  5, 1, 1);
    send(5, OP_READ, 5, 1, 0);
    wait_cpl(5, "R7 sized ops complete");
    chk(got[1] == 64'hFFFF_FFFF, "R7 4-byte old value zero-extended", got[1], 64'hFFFF_FFFF);
    chk(got[2] == 64'h1111_2222_0000_0000, "R7 4-byte add wraps, upper kept", got[2], 64'h1111_2222_0000_0000);
    chk(got[3] == 0, "R7 4-byte read", got[3], 0);
    chk(got[5] == 64'h1_0000_0000, "R7 8-byte add carries", got[5], 64'h1_0000_0000);
  endtask

  task automatic t_parallel();
    clear();
    max_out = 0;
    for (int i = 0; i < 4; i++) mem_words[8 + i] = 64'(100 + i);
    for (int i = 0; i < 4; i++) send(i + 1, OP_READ, 8 + i, 1, 0);
    wait_cpl(4, "R9 parallel reads complete");
    chk(max_out >= 2, "R9 distinct addresses overlap", 64'(max_out), 2);
    for (int i = 0; i < 4; i++) chk(got[i + 1] == 64'(100 + i), "R9 parallel read data", got[i + 1], 64'(100 + i));
  endtask

  task automatic t_backpressure();
    clear();
    hold_rsp = 1;
    for (int i = 0; i < 4; i++) send(i + 1, OP_READ, 12, 1, 0);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 12; req_op = OP_READ;
    #0.5;
    chk(!req_ready, "R10 full FIFO blocks", 64'(req_ready), 0);
    req_valid = 1'b0;
    for (int i = 0; i < 3; i++) send(5 + i, OP_READ, 13 + i, 1, 0);
    @(negedge clk);
    req_addr = 0;
    #0.5;
    chk(!req_ready, "R10 no free entry blocks new address", 64'(req_ready), 0);
    req_addr = 13;
    #0.1;
    chk(req_ready, "R10 tracked address with room accepted", 64'(req_ready), 1);
    hold_rsp = 0;
    wait_cpl(7, "R10 held requests drain");
    mem_words[0] = 64'h77;
    send(8, OP_READ, 0, 1, 0);
    wait_cpl(8, "R10 freed entry reused");
    chk(got[8] == 64'h77, "R10 reuse read data", got[8], 64'h77);
  endtask

  task automatic t_stall();
    clear();
    stall_err = 0;
    stall_mode = 1;
    mem_words[6] = 7;
    mem_words[7] = 42;
    send(1, OP_ADD,  6, 1, 3);
    send(2, OP_READ, 6, 1, 0);
    send(3, OP_READ, 7, 1, 0);
    wait_cpl(3, "R12 stalled run completes");
    stall_mode = 0;
    chk(got[1] == 7 && got[2] == 10 && got[3] == 42, "R12 results under stall", got[2], 10);
    chk(stall_err == 0, "R12 request held while stalled", 64'(stall_err), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem_words[i] = '0;
      out_cnt[i] = 0;
    end
    t_reset();
    t_latency();
    t_order();
    t_ops();
    t_size4();
    t_parallel();
    t_backpressure();
    t_stall();
    chk(dup_cpl == 0, "R11 one completion per request", 64'(dup_cpl), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule